// File: doc/BRIEF.md
# Two-Wire Slave Port for Display Register Access

This block is a serial slave that lets a host on a two-wire bus reach a display controller. A host can write the index register, write the control registers or display RAM through the write-data path, read a status word, and read display RAM. The block oversamples the clock and data lines on a fast system clock. It detects start and stop conditions, checks a 6-bit device address and takes two selector bits from the first byte. It then either assembles 16-bit words from byte pairs or shifts 16-bit words out as byte pairs.

The first byte carries a fixed 5-bit prefix, then a bit that must equal the level on an external identity pin, then a register-select flag, and last a direction flag. On the register side the block raises a single-cycle write strobe that carries the register-select value and the assembled word. During a display RAM read it raises a single-cycle fetch request each time it takes a new RAM word. The data line output is open-drain: one output bit asks for the line to be pulled low, and otherwise the line is released.

Top module: `i2c_disp_port`

## Requirements
- R1: After an active-low reset, `sda_oe_o`, `wr_stb_o` and `ram_rd_req_o` are all 0.
- R2: A falling SDA while SCL is high starts a transfer, including in the middle of another one, and discards a half-received word. A rising SDA while SCL is high ends the transfer and leaves SDA released.
- R3: The first byte is sent MSB first. Its bits 7..3 must be 01110 and bit 2 must equal `id_i`. Bit 1 is the register-select flag RS and bit 0 is the read/write flag (1 = read). On a match the block pulls SDA low during the ninth clock.
- R4: On an address mismatch the block gives no acknowledge, drives nothing and raises no strobe until the next start or stop.
- R5: In a write, every data byte after the first byte is acknowledged by pulling SDA low during its ninth clock.
- R6: Write bytes pair up high byte first. One system clock after the acknowledge slot of each low byte ends, `wr_stb_o` is high for exactly one clock, with `wr_data_o` = {high, low}.
- R7: `wr_rs_o` carries the RS bit of the first byte: 0 marks an index write and 1 marks a control or RAM write.
- R8: A read with RS=0 returns `status_i` as byte pairs, high byte first and MSB first, and repeats for as long as the master acknowledges.
- R9: A read with RS=1 returns five filler bytes of value 0xFF. After that come RAM words as byte pairs, high byte first. `ram_rd_req_o` pulses once each time a word is taken from `ram_rdata_i`, at the start of its high byte.
- R10: A master NACK after a read byte ends the read. SDA then stays released for any further clocks until the next start or stop.
- R11: `sda_oe_o` changes only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| id_i | input | 1 | Level that the address bit 2 must match |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| status_i | input | 16 | Status word for RS=0 reads |
| ram_rdata_i | input | 16 | Current display RAM read word |
| ram_rd_req_o | output | 1 | One-cycle pulse when a RAM word is taken |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_rs_o | output | 1 | Register-select value for the write |
| wr_data_o | output | 16 | Assembled write word |

## Verification
The hardest states to reach are the tail of a RAM read and the interplay of NACK, restart and a half-filled word pair. To reach RAM data at all, the master has to clock through all five filler bytes. To show that a pending high byte is dropped, a new start has to land between the two bytes of a pair. The stimulus is a bit-level bus master in the bench. It runs long reads past the filler and issues a repeated start after a single write byte. After a NACK it keeps clocking a further byte and checks that the line stays high throughout.

// File: rtl/i2c_disp_pkg.sv
package i2c_disp_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [4:0] DEV_PREFIX = 5'b01110;
  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RX, ST_ACKW, ST_ACKH, ST_ACKE,
    ST_TX, ST_MACK, ST_MACKE, ST_IGN
  } port_st_e;

  function automatic logic addr_match(input logic [BYTE_W-1:0] b, input logic id);
    return (b[7:3] == DEV_PREFIX) && (b[2] == id);
  endfunction

  function automatic logic [WORD_W-1:0] join_word(input logic [BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BYTE_W-1:0] upper_byte(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:BYTE_W];
  endfunction

  function automatic logic [BYTE_W-1:0] lower_byte(input logic [WORD_W-1:0] w);
    return w[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/i2c_word_pack.sv
module i2c_word_pack
  import i2c_disp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rs_i,
  output logic              wr_stb_o,
  output logic              wr_rs_o,
  output logic [WORD_W-1:0] wr_data_o
);
  logic              have_hi;
  logic [BYTE_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_hi   <= 1'b0;
      hi_q      <= '0;
      wr_stb_o  <= 1'b0;
      wr_rs_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (clr_i) begin
        have_hi <= 1'b0;
      end else if (byte_vld_i) begin
        if (!have_hi) begin
          hi_q    <= byte_i;
          have_hi <= 1'b1;
        end else begin
          wr_data_o <= join_word(hi_q, byte_i);
          wr_rs_o   <= rs_i;
          wr_stb_o  <= 1'b1;
          have_hi   <= 1'b0;
        end
      end
    end
  end

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o); // R6
  AST_PAIR_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> !have_hi); // R6
endmodule

// File: rtl/i2c_rd_serial.sv
module i2c_rd_serial
  import i2c_disp_pkg::*;
#(
  parameter int FILLER_BYTES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              is_ram_i,
  input  logic [WORD_W-1:0] status_i,
  input  logic [WORD_W-1:0] ram_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ram_req_o
);
  localparam int CNT_W = $clog2(FILLER_BYTES + 1);
  localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(FILLER_BYTES);

  logic [CNT_W-1:0]  fill_cnt;
  logic              lo_next;
  logic [BYTE_W-1:0] lo_q;
  logic [WORD_W-1:0] src_word;
  logic              in_filler;

  assign src_word  = is_ram_i ? ram_i : status_i;
  assign in_filler = is_ram_i && (fill_cnt != FILL_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt  <= '0;
      lo_next   <= 1'b0;
      lo_q      <= '0;
      byte_o    <= FILL_BYTE;
      ram_req_o <= 1'b0;
    end else begin
      ram_req_o <= 1'b0;
      if (clr_i) begin
        fill_cnt <= '0;
        lo_next  <= 1'b0;
      end else if (load_i) begin
        if (in_filler) begin
          byte_o   <= FILL_BYTE;
          fill_cnt <= fill_cnt + 1'b1;
        end else if (!lo_next) begin
          byte_o    <= upper_byte(src_word);
          lo_q      <= lower_byte(src_word);
          lo_next   <= 1'b1;
          ram_req_o <= is_ram_i;
        end else begin
          byte_o  <= lo_q;
          lo_next <= 1'b0;
        end
      end
    end
  end

  AST_REQ_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req_o |-> (fill_cnt == FILL_LAST)); // R9
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req_o |=> !ram_req_o); // R9
endmodule

// File: rtl/i2c_disp_port.sv
module i2c_disp_port
  import i2c_disp_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int FILLER_BYTES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              id_i,
  output logic              sda_oe_o,
  input  logic [WORD_W-1:0] status_i,
  input  logic [WORD_W-1:0] ram_rdata_i,
  output logic              ram_rd_req_o,
  output logic              wr_stb_o,
  output logic              wr_rs_o,
  output logic [WORD_W-1:0] wr_data_o
);
  localparam int BCNT_W = $clog2(BYTE_W + 1);
  localparam logic [BCNT_W-1:0] LAST_BIT  = BCNT_W'(BYTE_W - 1);
  localparam logic [BCNT_W-1:0] BYTE_DONE = BCNT_W'(BYTE_W);

  logic [1:0] lines_s;
  logic       scl_s, sda_s, scl_q, sda_q;
  logic       scl_rise, scl_fall, start_ev, stop_ev;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(lines_s));

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // bus events seen on the synchronised lines
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

  port_st_e          state;
  logic [BCNT_W-1:0] bitcnt;
  logic [BYTE_W-1:0] sh;
  logic              first_byte, sel_rs, sel_rw, selected, tx_arm;
  logic [BYTE_W-1:0] tx_byte;
  logic [2:0]        tx_idx;
  logic              tx_load, wbyte_done;

  assign tx_idx     = 3'(LAST_BIT - bitcnt);
  assign tx_load    = scl_fall && (((state == ST_ACKE) && first_byte && sel_rw) ||
                                   (state == ST_MACKE));
  assign wbyte_done = scl_fall && (state == ST_ACKE) && !first_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      sh         <= '0;
      sda_oe_o   <= 1'b0;
      first_byte <= 1'b0;
      sel_rs     <= 1'b0;
      sel_rw     <= 1'b0;
      selected   <= 1'b0;
      tx_arm     <= 1'b0;
    end else if (start_ev) begin
      state      <= ST_RX;
      bitcnt     <= '0;
      sda_oe_o   <= 1'b0;
      first_byte <= 1'b1;
      selected   <= 1'b0;
      tx_arm     <= 1'b0;
    end else if (stop_ev) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
      selected <= 1'b0;
      tx_arm   <= 1'b0;
    end else begin
      tx_arm <= 1'b0;
      if (tx_arm) sda_oe_o <= ~tx_byte[tx_idx];
      unique case (state)
        ST_RX: if (scl_rise) begin
          sh     <= {sh[BYTE_W-2:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LAST_BIT) state <= ST_ACKW;
        end
        ST_ACKW: if (scl_fall) begin
          if (first_byte && !addr_match(sh, id_i)) begin
            state <= ST_IGN;
          end else begin
            sda_oe_o <= 1'b1;
            state    <= ST_ACKH;
            if (first_byte) begin
              selected <= 1'b1;
              sel_rs   <= sh[1];
              sel_rw   <= sh[0];
            end
          end
        end
        ST_ACKH: if (scl_rise) state <= ST_ACKE;
        ST_ACKE: if (scl_fall) begin
          sda_oe_o   <= 1'b0;
          bitcnt     <= '0;
          first_byte <= 1'b0;
          if (first_byte && sel_rw) begin
            state  <= ST_TX;
            tx_arm <= 1'b1;
          end else begin
            state <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) bitcnt <= bitcnt + 1'b1;
          if (scl_fall) begin
            if (bitcnt == BYTE_DONE) begin
              sda_oe_o <= 1'b0;
              state    <= ST_MACK;
            end else begin
              tx_arm <= 1'b1;
            end
          end
        end
        ST_MACK: if (scl_rise) state <= sda_s ? ST_IGN : ST_MACKE;
        ST_MACKE: if (scl_fall) begin
          state  <= ST_TX;
          bitcnt <= '0;
          tx_arm <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  i2c_word_pack u_pack (
    .clk(clk), .rst_n(rst_n), .clr_i(start_ev), .byte_vld_i(wbyte_done),
    .byte_i(sh), .rs_i(sel_rs), .wr_stb_o(wr_stb_o), .wr_rs_o(wr_rs_o),
    .wr_data_o(wr_data_o));

  i2c_rd_serial #(.FILLER_BYTES(FILLER_BYTES)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr_i(start_ev), .load_i(tx_load),
    .is_ram_i(sel_rs), .status_i(status_i), .ram_i(ram_rdata_i),
    .byte_o(tx_byte), .ram_req_o(ram_rd_req_o));

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_s)); // R11
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe_o); // R2
  AST_ACK_ONLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_ACKH) && first_byte) |-> (selected && sda_oe_o)); // R3
  AST_IGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGN) |-> !sda_oe_o); // R4
  AST_NO_WR_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> !sel_rw); // R6
  AST_REQ_RAM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_req_o |-> (sel_rs && sel_rw)); // R9
endmodule

// File: tb/i2c_disp_port_tb_top.sv
module i2c_disp_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic m_low = 1'b0;
  logic id_pin = 1'b0;
  logic [15:0] status_w = 16'hA55A;
  logic [15:0] ram_word = 16'hC000;
  logic sda_oe, ram_req, wr_stb, wr_rs;
  logic [15:0] wr_data;
  wire sda_bus = ~(m_low | sda_oe);

  int checks = 0;
  int fails = 0;
  int req_cnt = 0;
  int cyc = 0;
  logic [16:0] exp_q[$];
  logic [16:0] exp_e;
  logic oe_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_disp_port dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .id_i(id_pin),
    .sda_oe_o(sda_oe), .status_i(status_w), .ram_rdata_i(ram_word),
    .ram_rd_req_o(ram_req), .wr_stb_o(wr_stb), .wr_rs_o(wr_rs), .wr_data_o(wr_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected write", {15'd0, wr_rs, wr_data}, 0);
        else begin
          exp_e = exp_q.pop_front();
          chk({wr_rs, wr_data} == exp_e, "R6/R7 write word", {15'd0, wr_rs, wr_data}, exp_e);
        end
      end
      if (sda_oe != oe_prev) chk(!scl_m, "R11 oe change while SCL low", scl_m, 0);
      if (ram_req) begin
        req_cnt++;
        ram_word = ram_word + 16'd1;
      end
    end
    oe_prev = sda_oe;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_low = 1'b0; wq(); scl_m = 1'b1; wq(); m_low = 1'b1; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(); scl_m = 1'b1; wq(); m_low = 1'b0; wq(); wq();
  endtask

  task automatic send_bit(input bit b);
    m_low = ~b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_bit(output bit b);
    m_low = 1'b0; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    acked = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit nack);
    bit b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(nack);
  endtask

  function automatic logic [7:0] first_b(input bit idb, input bit rs, input bit rw);
    return {5'b01110, idb, rs, rw};
  endfunction

  initial begin
    bit ack;
    logic [7:0] rb;
    logic [7:0] expb;
    repeat (3) @(negedge clk);
    chk(sda_oe == 1'b0 && wr_stb == 1'b0 && ram_req == 1'b0, "R1 reset outputs",
        {sda_oe, wr_stb, ram_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // index write, RS=0
    exp_q.push_back({1'b0, 16'h1234});
    bus_start();
    send_byte(first_b(1'b0, 1'b0, 1'b0), ack); chk(ack, "R3 address ack", ack, 1);
    send_byte(8'h12, ack); chk(ack, "R5 high byte ack", ack, 1);
    send_byte(8'h34, ack); chk(ack, "R5 low byte ack", ack, 1);
    bus_stop();
    chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
    chk(exp_q.size() == 0, "R6 index write seen", exp_q.size(), 0);

    // control/RAM write, RS=1, two words
    exp_q.push_back({1'b1, 16'hBEEF});
    exp_q.push_back({1'b1, 16'h0102});
    bus_start();
    send_byte(first_b(1'b0, 1'b1, 1'b0), ack); chk(ack, "R3 address ack RS=1", ack, 1);
    send_byte(8'hBE, ack); send_byte(8'hEF, ack);
    send_byte(8'h01, ack); send_byte(8'h02, ack); chk(ack, "R5 fourth byte ack", ack, 1);
    bus_stop();
    chk(exp_q.size() == 0, "R7 two RS=1 writes seen", exp_q.size(), 0);

    // identity pin set to 1: bit 2 = 0 must not match
    id_pin = 1'b1;
    bus_start();
    send_byte(first_b(1'b0, 1'b0, 1'b0), ack); chk(!ack, "R4 id mismatch no ack", ack, 0);
    send_byte(8'h55, ack); chk(!ack, "R4 ignored byte no ack", ack, 0);
    send_byte(8'hAA, ack); chk(!ack, "R4 ignored byte no ack", ack, 0);
    bus_stop();
    exp_q.push_back({1'b0, 16'h0A0B});
    bus_start();
    send_byte(first_b(1'b1, 1'b0, 1'b0), ack); chk(ack, "R3 id=1 match ack", ack, 1);
    send_byte(8'h0A, ack); send_byte(8'h0B, ack);
    bus_stop();
    chk(exp_q.size() == 0, "R3 write after id match", exp_q.size(), 0);

    // wrong prefix
    bus_start();
    send_byte(8'b01111100, ack); chk(!ack, "R3 wrong prefix no ack", ack, 0);
    send_byte(8'h11, ack); send_byte(8'h22, ack); chk(!ack, "R4 ignored data", ack, 0);
    bus_stop();

    // restart between the bytes of a pair
    exp_q.push_back({1'b0, 16'h5566});
    bus_start();
    send_byte(first_b(1'b1, 1'b0, 1'b0), ack);
    send_byte(8'h99, ack);
    bus_start();
    send_byte(first_b(1'b1, 1'b0, 1'b0), ack); chk(ack, "R2 restart address ack", ack, 1);
    send_byte(8'h55, ack); send_byte(8'h66, ack);
    bus_stop();
    chk(exp_q.size() == 0, "R2 half word dropped on restart", exp_q.size(), 0);

    // status read
    bus_start();
    send_byte(first_b(1'b1, 1'b0, 1'b1), ack); chk(ack, "R3 status read ack", ack, 1);
    for (int i = 0; i < 4; i++) begin
      recv_byte(rb, i == 3);
      expb = (i % 2 == 0) ? status_w[15:8] : status_w[7:0];
      chk(rb == expb, "R8 status byte", rb, expb);
    end
    recv_byte(rb, 1'b1);
    chk(rb == 8'hFF, "R10 released after NACK", rb, 8'hFF);
    bus_stop();

    // RAM read
    req_cnt = 0;
    bus_start();
    send_byte(first_b(1'b1, 1'b1, 1'b1), ack); chk(ack, "R3 RAM read ack", ack, 1);
    for (int i = 0; i < 9; i++) begin
      recv_byte(rb, i == 8);
      case (i)
        0, 1, 2, 3, 4: expb = 8'hFF;
        5, 7:          expb = 8'hC0;
        6:             expb = 8'h00;
        default:       expb = 8'h01;
      endcase
      chk(rb == expb, "R9 RAM read byte", rb, expb);
    end
    chk(req_cnt == 2, "R9 RAM fetch count", req_cnt, 2);
    recv_byte(rb, 1'b1);
    chk(rb == 8'hFF, "R10 no drive after NACK", rb, 8'hFF);
    chk(req_cnt == 2, "R10 no fetch after NACK", req_cnt, 2);
    bus_stop();
    chk(sda_oe == 1'b0, "R2 released at end", sda_oe, 0);
    chk(exp_q.size() == 0, "R6 no pending writes", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule